// File: doc/BRIEF.md
# Prescaled Down-Counter Timer with Dual-Mode Control

This block is an 8-bit timer that counts down. A 7-stage binary prescaler feeds it. The prescaler takes its input pulses from one of two sources. The first is an internal clock-enable strobe, which the external pin level may gate. The second is a rising edge on the external timer pin, after that pin has passed through a two-flop synchronizer. A selected prescaler stage produces a tick, and each tick lowers the counter by one. When a tick takes the counter to zero, a sticky request flag is set. An unmasked request drives the interrupt output.

A CPU reaches the block through a small register bus with two addresses: the counter value and an 8-bit control register. A static mode input gives the control register one of two behaviours:

- **Software mode:** the CPU owns the divide select, the clock-source select and the pin-gating enable.
- **Option mode:** the divide select and the clock source come from static option inputs, and pin gating is always on. CPU writes to these fields are dropped, and the fields read back as ones.

In both modes the request flag and the mask bit behave in the same way. A write-only bit resets the prescaler so that the next input pulse makes a full tick.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads 8'hFF, the control register reads 8'h40 in software mode (mask bit 6 set, all other bits zero), and `irq` is low.
- R2: The control field bits 2..0 hold a value n that sets a division of 2^n (1 to 128). Right after a prescaler clear, P input pulses lower the counter by ceil(P / 2^n).
- R3: Writing the control register with bit 3 set forces all prescaler stages to one, so the next input pulse gives a tick at any ratio. Bit 3 always reads as zero.
- R4: A write to the counter address (`busAddr`=0) loads the counter with the write data and leaves the prescaler phase unchanged.
- R5: Bit 7 of the control register (the request) becomes one on the edge where a tick moves the counter from 1 to 0.
- R6: Only reset or a control write with bit 7 at zero clears the request. Writing a one there has no effect. If a clear write and a set event fall in the same cycle, the request stays set.
- R7: `irq` is high exactly when the request bit is one and the mask bit (bit 6) is zero.
- R8: When control bit 5 is one, each rising edge of `extPin`, seen after two synchronizer flops, is one input pulse, and `clkEn` is ignored. A pin held high gives only one pulse.
- R9: When bit 5 is zero and control bit 4 is one, `clkEn` counts only while the synchronized `extPin` is high.
- R10: While `optMode` is high, the divide select comes from `optPsSel` and the clock source from `optExtSrc`, and pin gating is forced on. Writes to bits 5, 4 and 2..0 are ignored, and those bits read as ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| optMode | input | 1 | Static mode select: 1 = option mode |
| optPsSel | input | 3 | Divide select used in option mode |
| optExtSrc | input | 1 | Clock source used in option mode (1 = pin edge) |
| busAddr | input | 1 | Register select: 0 = counter, 1 = control |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected register (combinational) |
| clkEn | input | 1 | Internal clock-enable strobe |
| extPin | input | 1 | External timer input, asynchronous |
| irq | output | 1 | Interrupt output |

## Verification
Two events can land on the same clock edge: the hardware setting of the request as the counter reaches zero, and a CPU control write that clears the request. The bench first sets the request, then reloads the counter with 1. It then holds `clkEn` high during the very cycle in which it writes the control register with bit 7 at zero. The request must still read as one, the counter must read zero, and `irq` must be high.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 8;
  localparam int PS_W   = 7;
  localparam int SEL_W  = $clog2(PS_W + 1);

  typedef struct packed {
    logic              cntLoad;
    logic              psClear;
    logic              inPulse;
    logic [DATA_W-1:0] loadVal;
    logic [SEL_W-1:0]  psSel;
  } strobe_t;
endpackage

// File: rtl/tick_timer_dpath.sv
module tick_timer_dpath
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] count,
  output logic              tick,
  output logic              zeroEvt
);
  logic [PS_W-1:0]   psQ;
  logic [DATA_W-1:0] cntQ;
  logic              lowOnes;

  // Stages below the selected one must all be one for the pulse to carry out.
  always_comb begin
    lowOnes = 1'b1;
    for (int i = 0; i < PS_W; i++) begin
      if ((i < int'(strb.psSel)) && !psQ[i]) lowOnes = 1'b0;
    end
  end

  assign tick    = strb.inPulse && lowOnes;
  assign zeroEvt = tick && !strb.cntLoad && (cntQ == DATA_W'(1));
  assign count   = cntQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psQ <= '0;
    end else if (strb.psClear) begin
      psQ <= '1;
    end else if (strb.inPulse) begin
      psQ <= psQ + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '1;
    end else if (strb.cntLoad) begin
      cntQ <= strb.loadVal;
    end else if (tick) begin
      cntQ <= cntQ - DATA_W'(1);
    end
  end
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              optMode,
  input  logic [SEL_W-1:0]  optPsSel,
  input  logic              optExtSrc,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              clkEn,
  input  logic              extPin,
  input  logic [DATA_W-1:0] count,
  input  logic              zeroEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              irqReq,
  output strobe_t           strb
);
  logic                   reqQ, maskQ, srcQ, gateQ;
  logic [SEL_W-1:0]       selQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   pinLvl, ctlWr;
  logic                   effSrc, effGate;
  logic [SEL_W-1:0]       effSel;
  logic [DATA_W-1:0]      ctlView;

  assign ctlWr  = busWr && busAddr;
  assign pinLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      prevQ <= pinLvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqQ  <= 1'b0;
      maskQ <= 1'b1;
      srcQ  <= 1'b0;
      gateQ <= 1'b0;
      selQ  <= '0;
    end else begin
      if (zeroEvt) reqQ <= 1'b1;
      else if (ctlWr && !busWdata[7]) reqQ <= 1'b0;
      if (ctlWr) maskQ <= busWdata[6];
      if (ctlWr && !optMode) begin
        srcQ  <= busWdata[5];
        gateQ <= busWdata[4];
        selQ  <= busWdata[SEL_W-1:0];
      end
    end
  end

  assign effSrc  = optMode ? optExtSrc : srcQ;
  assign effGate = optMode ? 1'b1 : gateQ;
  assign effSel  = optMode ? optPsSel : selQ;

  always_comb begin
    strb.cntLoad = busWr && !busAddr;
    strb.psClear = ctlWr && busWdata[3];
    strb.loadVal = busWdata;
    strb.psSel   = effSel;
    strb.inPulse = effSrc ? (pinLvl && !prevQ)
                          : (clkEn && (pinLvl || !effGate));
  end

  assign ctlView = {reqQ, maskQ, optMode | srcQ, optMode | gateQ, 1'b0,
                    optMode ? {SEL_W{1'b1}} : selQ};
  assign busRdata = busAddr ? ctlView : count;
  assign irqReq   = reqQ;
  assign irq      = reqQ && !maskQ;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              optMode,
  input  logic [SEL_W-1:0]  optPsSel,
  input  logic              optExtSrc,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              clkEn,
  input  logic              extPin,
  output logic              irq
);
  strobe_t           strb;
  logic [DATA_W-1:0] count;
  logic              tick, zeroEvt, irqReq;

  tick_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .optMode(optMode), .optPsSel(optPsSel),
    .optExtSrc(optExtSrc), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .clkEn(clkEn), .extPin(extPin), .count(count),
    .zeroEvt(zeroEvt), .busRdata(busRdata), .irq(irq), .irqReq(irqReq),
    .strb(strb)
  );

  tick_timer_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .count(count),
    .tick(tick), .zeroEvt(zeroEvt)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              optMode,
  input logic              busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irq,
  input logic              irqReq,
  input logic              zeroEvt,
  input logic              tick,
  input logic              cntLoad,
  input logic [DATA_W-1:0] count
);
  // R5
  req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zeroEvt |=> irqReq);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq && !(busWr && busAddr && !busWdata[7]) |=> irqReq);

  // R6
  req_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irqReq && !zeroEvt |=> !irqReq);

  // R7
  irq_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irqReq);

  // R2
  count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cntLoad && !tick |=> $stable(count));

  // R4
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntLoad |=> count == $past(busWdata));

  // R3
  clear_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busAddr |-> !busRdata[3]);

  // R10
  opt_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    optMode && busAddr |-> (busRdata[5:4] == 2'b11) && (busRdata[2:0] == 3'b111));
endmodule

bind tick_timer tick_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .optMode(optMode), .busAddr(busAddr),
  .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
  .irqReq(irqReq), .zeroEvt(zeroEvt), .tick(tick), .cntLoad(strb.cntLoad),
  .count(count)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       optMode = 1'b0;
  logic [2:0] optPsSel = 3'd0;
  logic       optExtSrc = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       clkEn = 1'b0;
  logic       extPin = 1'b0;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .optMode(optMode), .optPsSel(optPsSel),
    .optExtSrc(optExtSrc), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .clkEn(clkEn),
    .extPin(extPin), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic runEn(input int p);
    @(negedge clk);
    clkEn = 1'b1;
    repeat (p) @(posedge clk);
    @(negedge clk);
    clkEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rd(1'b0, v); check("R1 counter", v, 8'hFF);
    rd(1'b1, v); check("R1 control", v, 8'h40);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic ratio(input logic [2:0] n, input int p);
    logic [7:0] v;
    int ticks;
    wr(1'b1, 8'h48 | {5'd0, n});
    wr(1'b0, 8'd200);
    runEn(p);
    ticks = (p + (1 << n) - 1) >> n;
    rd(1'b0, v); check("R2 R3 count after divided run", v, 8'(200 - ticks));
  endtask

  task automatic testRatios();
    logic [7:0] v;
    ratio(3'd0, 20);
    ratio(3'd7, 20);
    ratio(3'd3, 20);
    // prescaler now 0x7F+20 -> low 3 bits = 3; 5th pulse carries
    wr(1'b0, 8'd100);
    runEn(4);
    rd(1'b0, v); check("R4 load keeps phase (no tick yet)", v, 8'd100);
    runEn(1);
    rd(1'b0, v); check("R4 load keeps phase (tick)", v, 8'd99);
    rd(1'b1, v); check("R3 bit3 reads zero", v, 8'h43);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    wr(1'b1, 8'h08);
    wr(1'b0, 8'd2);
    runEn(1);
    rd(1'b1, v); check("R5 no request at 1", v, 8'h00);
    runEn(1);
    rd(1'b0, v); check("R5 count zero", v, 8'h00);
    rd(1'b1, v); check("R5 request set", v, 8'h80);
    check("R7 irq unmasked", {7'd0, irq}, 8'h01);
    wr(1'b1, 8'hC0);
    rd(1'b1, v); check("R6 write one keeps request", v, 8'hC0);
    check("R7 irq masked", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h80);
    check("R7 irq unmasked again", {7'd0, irq}, 8'h01);
    runEn(1);
    rd(1'b0, v); check("R5 wrap to FF", v, 8'hFF);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R6 write zero clears", v, 8'h00);
    check("R7 irq low after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic testCollision();
    logic [7:0] v;
    wr(1'b0, 8'd1);
    runEn(1);
    wr(1'b0, 8'd1);
    @(negedge clk);
    busAddr = 1'b1; busWdata = 8'h00; busWr = 1'b1; clkEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0; clkEn = 1'b0;
    rd(1'b1, v); check("R6 set wins over same-cycle clear", v, 8'h80);
    rd(1'b0, v); check("R6 collision count", v, 8'h00);
    check("R7 collision irq", {7'd0, irq}, 8'h01);
    wr(1'b1, 8'h40);
  endtask

  task automatic testExtSrc();
    logic [7:0] v;
    wr(1'b1, 8'h68);
    wr(1'b0, 8'd10);
    @(negedge clk);
    clkEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      extPin = 1'b1; idle(3);
      extPin = 1'b0; idle(3);
    end
    idle(4);
    rd(1'b0, v); check("R8 three pin edges", v, 8'd7);
    extPin = 1'b1; idle(12);
    rd(1'b0, v); check("R8 held pin one pulse", v, 8'd6);
    clkEn = 1'b0; extPin = 1'b0; idle(4);
  endtask

  task automatic testGate();
    logic [7:0] v;
    wr(1'b1, 8'h58);
    wr(1'b0, 8'd50);
    runEn(10);
    rd(1'b0, v); check("R9 gated off by low pin", v, 8'd50);
    @(negedge clk); extPin = 1'b1; idle(4);
    runEn(10);
    rd(1'b0, v); check("R9 counts with pin high", v, 8'd40);
    rd(1'b1, v); check("R9 control readback", v, 8'h50);
  endtask

  task automatic testOption();
    logic [7:0] v;
    optMode = 1'b1; optPsSel = 3'd2; optExtSrc = 1'b0; extPin = 1'b1;
    doReset();
    idle(3);
    rd(1'b1, v); check("R10 reads ones after reset", v, 8'h77);
    wr(1'b1, 8'h0F);
    rd(1'b1, v); check("R10 writes ignored", v, 8'h37);
    wr(1'b0, 8'd50);
    runEn(9);
    rd(1'b0, v); check("R10 divide from option inputs", v, 8'd47);
    @(negedge clk); extPin = 1'b0; idle(4);
    runEn(5);
    rd(1'b0, v); check("R10 gating forced on", v, 8'd47);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    doReset();
    testReset();
    testRatios();
    testIrq();
    testCollision();
    testExtSrc();
    testGate();
    testOption();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule